// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block is the command front end of a boot-block NOR flash model. It watches bus write cycles, each an address and a data byte offered on a valid/ready write channel, and picks out the block-erase instruction. The instruction has two unlock writes, a set-up write, two more unlock writes and a confirm write. The address of the confirm write picks the block to erase. A `word_mode` pin selects between the byte-wide and word-wide address conventions.

After the first confirm, more confirm writes may follow with no unlock writes. Each one adds its block to a one-bit-per-block erase list and restarts an erase-start timeout. While the sequencer is timing or erasing, reads would return status instead of array data, and `status_mode` is high. `tmr_flag` reads 0 while the timeout runs and 1 once erasing has begun. When the timeout expires, the list goes to an erase engine stub. The stub spends a fixed number of cycles on each listed block and then returns the sequencer to read-array mode. A write that breaks the sequence returns the sequencer to read-array mode at once.

The write channel applies back-pressure only during the erase itself. `wr_ready` is low for the whole erase. A write offered then stays pending, with address and data held, until `wr_ready` returns. A write is taken on a rising clock edge with `wr_valid` and `wr_ready` both high.

Top module: `erase_seq_top`

## Requirements
- R1: After reset the sequencer is in read-array mode: `status_mode`=0, `tmr_flag`=0, `wr_ready`=1, `erase_list`=0.
- R2: The accepted writes AAh@A, 55h@B, 80h@A, AAh@A, 55h@B and then 30h at any address enter the timeout window (`status_mode`=1, `tmr_flag`=0). A is 0xAAA and B is 0x555 with `word_mode`=0. A is 0x555 and B is 0x2AA with `word_mode`=1. Only address bits [11:0] are compared.
- R3: The confirm write sets one bit of `erase_list`, at index `wr_addr[19:16]` in byte mode and `wr_addr[18:15]` in word mode.
- R4: Within the timeout window, each further 30h write ORs its block's bit into `erase_list` and needs no unlock writes.
- R5: `tmr_flag` rises exactly TMO_CYC cycles after the most recent accepted confirm. Each confirm restarts the count.
- R6: `status_mode` stays 1 from the first confirm until the erase completes. `tmr_flag` is 1 during the erase.
- R7: A write that does not match the expected unlock, set-up or confirm step returns the sequencer to read-array mode. A write other than 30h inside the timeout window does the same and clears `erase_list`.
- R8: The erase lasts BLK_CYC cycles per set bit of `erase_list`. The sequencer then returns to read-array mode with `erase_list` cleared, and `erase_busy` is high meanwhile.
- R9: `wr_ready` is 0 during the erase, so no write is taken then.
- R10: In read-array mode, a write that is not the first unlock (including a lone 30h) leaves the sequencer in read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1 = word-wide addressing, 0 = byte-wide |
| wr_valid | input | 1 | Write cycle offered |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | ADDR_W (20) | Write address |
| wr_data | input | 8 | Write data (command byte) |
| status_mode | output | 1 | Reads return status instead of array data |
| tmr_flag | output | 1 | 0 while the erase-start timeout runs, 1 while erasing |
| erase_busy | output | 1 | Erase engine stub is working |
| erase_list | output | 2**(ADDR_W-BLK_SHIFT) | Blocks queued for erase |

## Verification
Full erase sequences are applied in both address modes, so a swapped unlock address table or a wrong block-index slice shows up as a wrong `erase_list` bit. The high address bits vary on the unlock writes, which separates a 12-bit compare from a full-width one. Each unlock, set-up and confirm step is corrupted in turn, and a foreign command is sent inside the timeout window, so an abort to the wrong state or an uncleared list is caught. Cycle counts of the timeout, with and without a restarting confirm, and of a two-block erase distinguish off-by-one and non-restarting timers from the correct one.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    S_READ,
    S_C1,
    S_C2,
    S_C3,
    S_C4,
    S_C5,
    S_TMO,
    S_ERASE
  } seq_state_e;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_SETUP    = 8'h80;
  localparam logic [7:0] CMD_CONFIRM  = 8'h30;

  localparam logic [11:0] BYTE_ADR_A = 12'hAAA;
  localparam logic [11:0] BYTE_ADR_B = 12'h555;
  localparam logic [11:0] WORD_ADR_A = 12'h555;
  localparam logic [11:0] WORD_ADR_B = 12'h2AA;
endpackage

// File: rtl/erase_cmd_decode.sv
module erase_cmd_decode #(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 16,
  parameter int BLK_W     = ADDR_W - BLK_SHIFT
) (
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              is_ua,
  output logic              is_ub,
  output logic              is_setup,
  output logic              is_conf,
  output logic [BLK_W-1:0]  blk_idx
);
  import erase_seq_pkg::*;

  logic [11:0] adr_a, adr_b;

  // unlock address pair depends on bus width
  assign adr_a = word_mode ? WORD_ADR_A : BYTE_ADR_A;
  assign adr_b = word_mode ? WORD_ADR_B : BYTE_ADR_B;

  assign is_ua    = (data == CMD_UNLOCK_A) && (addr[11:0] == adr_a);
  assign is_ub    = (data == CMD_UNLOCK_B) && (addr[11:0] == adr_b);
  assign is_setup = (data == CMD_SETUP)    && (addr[11:0] == adr_a);
  assign is_conf  = (data == CMD_CONFIRM);

  // word addresses are byte addresses shifted right by one
  assign blk_idx = word_mode ? addr[ADDR_W-2:BLK_SHIFT-1] : addr[ADDR_W-1:BLK_SHIFT];
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int TMO_CYC = 5000,
  parameter int CW      = $clog2(TMO_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = run && !restart && (cnt == CW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/erase_engine_stub.sv
module erase_engine_stub #(
  parameter int NBLK    = 16,
  parameter int BLK_CYC = 1000,
  parameter int CW      = $clog2(BLK_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] mask_in,
  output logic            busy,
  output logic            done
);
  logic [NBLK-1:0] pend;
  logic [NBLK-1:0] low;
  logic [CW-1:0]   cnt;
  logic            last;

  assign low  = pend & (~pend + 1'b1);
  assign busy = |pend;
  assign last = (cnt == CW'(BLK_CYC - 1));
  assign done = busy && last && (pend == low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      cnt  <= '0;
    end else if (start) begin
      pend <= mask_in;
      cnt  <= '0;
    end else if (busy) begin
      if (last) begin
        pend <= pend & ~low;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R8
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top #(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 16,
  parameter int TMO_CYC   = 5000,
  parameter int BLK_CYC   = 1000,
  parameter int BLK_W     = ADDR_W - BLK_SHIFT,
  parameter int NBLK      = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              status_mode,
  output logic              tmr_flag,
  output logic              erase_busy,
  output logic [NBLK-1:0]   erase_list
);
  import erase_seq_pkg::*;

  seq_state_e      state, state_nxt;
  logic [NBLK-1:0] list_q, list_nxt;
  logic            acc;
  logic            is_ua, is_ub, is_setup, is_conf;
  logic [BLK_W-1:0] blk_idx;
  logic [NBLK-1:0] blk_bit;
  logic            tmr_restart, tmr_expired;
  logic            eng_start, eng_busy, eng_done;

  erase_cmd_decode #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .BLK_W(BLK_W)
  ) i_dec (
    .word_mode(word_mode), .addr(wr_addr), .data(wr_data),
    .is_ua(is_ua), .is_ub(is_ub), .is_setup(is_setup), .is_conf(is_conf),
    .blk_idx(blk_idx)
  );

  erase_timer #(.TMO_CYC(TMO_CYC)) i_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
    .run(state == S_TMO), .expired(tmr_expired)
  );

  erase_engine_stub #(.NBLK(NBLK), .BLK_CYC(BLK_CYC)) i_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .mask_in(list_q),
    .busy(eng_busy), .done(eng_done)
  );

  assign wr_ready = (state != S_ERASE);
  assign acc      = wr_valid && wr_ready;
  assign blk_bit  = NBLK'(1) << blk_idx;

  always_comb begin
    state_nxt   = state;
    list_nxt    = list_q;
    tmr_restart = 1'b0;
    eng_start   = 1'b0;
    case (state)
      S_READ: if (acc && is_ua) state_nxt = S_C1;
      S_C1:   if (acc) state_nxt = is_ub    ? S_C2 : S_READ;
      S_C2:   if (acc) state_nxt = is_setup ? S_C3 : S_READ;
      S_C3:   if (acc) state_nxt = is_ua    ? S_C4 : S_READ;
      S_C4:   if (acc) state_nxt = is_ub    ? S_C5 : S_READ;
      S_C5: begin
        if (acc) begin
          if (is_conf) begin
            state_nxt   = S_TMO;
            list_nxt    = blk_bit;
            tmr_restart = 1'b1;
          end else begin
            state_nxt = S_READ;
          end
        end
      end
      S_TMO: begin
        if (acc) begin
          if (is_conf) begin
            list_nxt    = list_q | blk_bit;
            tmr_restart = 1'b1;
          end else begin
            state_nxt = S_READ;
            list_nxt  = '0;
          end
        end else if (tmr_expired) begin
          state_nxt = S_ERASE;
          eng_start = 1'b1;
        end
      end
      S_ERASE: begin
        if (eng_done) begin
          state_nxt = S_READ;
          list_nxt  = '0;
        end
      end
      default: state_nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_READ;
      list_q <= '0;
    end else begin
      state  <= state_nxt;
      list_q <= list_nxt;
    end
  end

  assign status_mode = (state == S_TMO) || (state == S_ERASE);
  assign tmr_flag    = (state == S_ERASE);
  assign erase_busy  = eng_busy;
  assign erase_list  = list_q;

  // R9
  no_take_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !wr_ready);
  // R4
  list_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TMO && $past(state) == S_TMO) |-> ((list_q & $past(list_q)) == $past(list_q)));
  // R7
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_TMO && state == S_READ) |-> (list_q == '0));
  // R6
  busy_means_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (status_mode && tmr_flag));
endmodule

// File: tb/test_erase_seq_top.sv
module test_erase_seq_top;
  localparam int CLK_PER   = 10;
  localparam int ADDR_W    = 20;
  localparam int BLK_SHIFT = 16;
  localparam int TMO_CYC   = 20;
  localparam int BLK_CYC   = 8;
  localparam int NBLK      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_mode = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic status_mode, tmr_flag, erase_busy;
  logic [NBLK-1:0] erase_list;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  erase_seq_top #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .TMO_CYC(TMO_CYC), .BLK_CYC(BLK_CYC)
  ) i_erase_seq_top (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .status_mode(status_mode), .tmr_flag(tmr_flag),
    .erase_busy(erase_busy), .erase_list(erase_list)
  );

  // vector: req(4) mode(1) addr(20) data(8) exp_status(1) exp_flag(1) exp_list(16)
  localparam int NV = 40;
  localparam logic [50:0] VEC [NV] = '{
    // R2 R3 R4 byte mode, then R7 abort in window
    {4'd2, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h00AAA, 8'h80, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd3, 1'b0, 20'h20000, 8'h30, 1'b1, 1'b0, 16'h0004},
    {4'd4, 1'b0, 20'h50000, 8'h30, 1'b1, 1'b0, 16'h0024},
    {4'd7, 1'b0, 20'h00000, 8'h00, 1'b0, 1'b0, 16'h0000},
    // R2 R3 R4 word mode
    {4'd2, 1'b1, 20'h00555, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b1, 20'h002AA, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b1, 20'h00555, 8'h80, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b1, 20'h00555, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b1, 20'h002AA, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd3, 1'b1, 20'h38000, 8'h30, 1'b1, 1'b0, 16'h0080},
    {4'd4, 1'b1, 20'h60000, 8'h30, 1'b1, 1'b0, 16'h1080},
    {4'd7, 1'b1, 20'h00000, 8'hF0, 1'b0, 1'b0, 16'h0000},
    // R7 bad second unlock
    {4'd7, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00555, 8'h12, 1'b0, 1'b0, 16'h0000},
    {4'd10, 1'b0, 20'h00AAA, 8'h80, 1'b0, 1'b0, 16'h0000},
    // R7 wrong confirm command
    {4'd7, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00AAA, 8'h80, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h20000, 8'h10, 1'b0, 1'b0, 16'h0000},
    // R10 byte addresses in word mode never unlock
    {4'd10, 1'b1, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd10, 1'b1, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd10, 1'b1, 20'h00AAA, 8'h80, 1'b0, 1'b0, 16'h0000},
    {4'd10, 1'b1, 20'h20000, 8'h30, 1'b0, 1'b0, 16'h0000},
    // R10 lone confirm
    {4'd10, 1'b0, 20'h00000, 8'h30, 1'b0, 1'b0, 16'h0000},
    // R2 high address bits ignored on unlock
    {4'd2, 1'b0, 20'h30AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h41555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'hFFAAA, 8'h80, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd2, 1'b0, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd3, 1'b0, 20'h1F000, 8'h30, 1'b1, 1'b0, 16'h0002},
    {4'd7, 1'b0, 20'h00000, 8'h90, 1'b0, 1'b0, 16'h0000},
    // R7 wrong set-up command
    {4'd7, 1'b0, 20'h00AAA, 8'hAA, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00555, 8'h55, 1'b0, 1'b0, 16'h0000},
    {4'd7, 1'b0, 20'h00AAA, 8'hA0, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic m, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    word_mode = m;
    wr_addr = a;
    wr_data = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock_setup(input logic m);
    if (m) begin
      wr(1'b1, 20'h555, 8'hAA); wr(1'b1, 20'h2AA, 8'h55); wr(1'b1, 20'h555, 8'h80);
      wr(1'b1, 20'h555, 8'hAA); wr(1'b1, 20'h2AA, 8'h55);
    end else begin
      wr(1'b0, 20'hAAA, 8'hAA); wr(1'b0, 20'h555, 8'h55); wr(1'b0, 20'hAAA, 8'h80);
      wr(1'b0, 20'hAAA, 8'hAA); wr(1'b0, 20'h555, 8'h55);
    end
  endtask

  initial begin
    int n;
    int m;
    logic [NBLK-1:0] exp_list;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status_mode == 1'b0 && tmr_flag == 1'b0 && wr_ready == 1'b1 && erase_list == '0,
        "R1", {status_mode, tmr_flag, wr_ready, erase_list}, {3'b001, 16'h0});
    rst_n = 1'b1;
    idle(2);
    chk(status_mode == 1'b0 && wr_ready == 1'b1, "R1", {status_mode, wr_ready}, 2'b01);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][46], VEC[v][45:26], VEC[v][25:18]);
      chk({status_mode, tmr_flag, erase_list} == VEC[v][17:0],
          $sformatf("R%0d vec%0d", VEC[v][50:47], v),
          {status_mode, tmr_flag, erase_list}, VEC[v][17:0]);
    end
    idle(TMO_CYC + 4);
    chk(status_mode == 1'b0, "R7", status_mode, 0);

    // R5 timeout length measured from a single confirm
    unlock_setup(1'b0);
    wr(1'b0, 20'h10000, 8'h30);
    n = 0;
    while (!tmr_flag && n < 1000) begin @(negedge clk); n++; end
    chk(n == TMO_CYC, "R5", n, TMO_CYC);
    // R8 R6 one-block erase
    m = 0;
    while (status_mode && m < 1000) begin
      chk(wr_ready == 1'b0 && tmr_flag == 1'b1 && erase_busy == 1'b1, "R9",
          {wr_ready, tmr_flag, erase_busy}, 3'b011);
      @(negedge clk); m++;
    end
    chk(m == BLK_CYC, "R8", m, BLK_CYC);
    chk(erase_list == '0 && wr_ready == 1'b1 && erase_busy == 1'b0, "R8",
        {erase_list, wr_ready, erase_busy}, 18'b10);

    // R5 restart by a second confirm, R4 chained block, R8 two-block erase
    unlock_setup(1'b1);
    wr(1'b1, 20'h08000, 8'h30);
    idle(5);
    chk(tmr_flag == 1'b0 && status_mode == 1'b1, "R6", {status_mode, tmr_flag}, 2'b10);
    wr(1'b1, 20'h48000, 8'h30);
    exp_list = 16'h0202;
    chk(erase_list == exp_list, "R4", erase_list, exp_list);
    n = 0;
    while (!tmr_flag && n < 1000) begin @(negedge clk); n++; end
    chk(n == TMO_CYC, "R5", n, TMO_CYC);
    // R9 a write offered during the erase is not taken
    wr_valid = 1'b1; word_mode = 1'b1; wr_addr = 20'h555; wr_data = 8'hAA;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(erase_list == exp_list && wr_ready == 1'b0, "R9", erase_list, exp_list);
    m = 1;
    while (status_mode && m < 1000) begin @(negedge clk); m++; end
    chk(m == BLK_CYC * $countones(exp_list), "R8", m, BLK_CYC * $countones(exp_list));
    chk(erase_list == '0 && status_mode == 1'b0, "R8", erase_list, 0);
    // R10 after erase a lone confirm does nothing
    wr(1'b0, 20'h30000, 8'h30);
    chk(status_mode == 1'b0 && erase_list == '0, "R10", status_mode, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule